// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Aligner

This combinational unit sits between a 32-bit word-wide data memory and the register file of a little-endian load/store core. The memory sees whole words only. The unit uses the two low bits of the effective address to pick byte lanes. On stores it produces the aligned word address, a per-lane write strobe and the write word with its bytes moved into position. On loads it takes the fetched word and produces the value to write back: either an extended byte or halfword, or, for the unaligned left/right loads, a merge of memory bytes with the old destination register.

A small control module decodes the operation code and byte offset into a set of lane strobes and a one-hot offset mask. A datapath module does the byte movement and the merging. A thin top joins the two modules and aligns the address.

Top module: `lsaAligner`

## Requirements
- R1: `memAddr` equals `effAddr` with its two low bits cleared. The offset `effAddr[1:0]` only selects lanes. Lane k is data bits [8k+7:8k].
- R2: `memOp` encoding: 1 byte store, 2 halfword store, 3 word store, 4 store-left, 5 store-right, 8 signed byte load, 9 unsigned byte load, 10 signed halfword load, 11 unsigned halfword load, 12 word load, 13 load-left, 14 load-right. Every other code, including 0, is no operation. A code that is not a store gives strobe 0000 and write data zero. A code that is not a load gives a load result of zero.
- R3: The word store strobe is 1111. The byte store strobe has only bit `off` set. The halfword store strobe is 1100 when address bit 1 is set and 0011 otherwise.
- R4: The store-left strobe for offsets 0/1/2/3 is 0001/0011/0111/1111. The store-right strobe is 1111/1110/1100/1000.
- R5: Byte and halfword stores copy `storeSrc[7:0]` or `storeSrc[15:0]` into every lane the strobe enables, and the disabled lanes are zero. A word store passes `storeSrc` through unchanged.
- R6: Store-left puts the top (off+1) bytes of `storeSrc` into lanes off..0, with the most significant byte of the source in lane `off`. The other lanes are zero.
- R7: Store-right puts the low (4-off) bytes of `storeSrc` into lanes 3..off, which is `storeSrc` shifted left by 8·off bits.
- R8: Byte loads return lane `off`, and halfword loads return lanes 3..2 when address bit 1 is set and lanes 1..0 otherwise. Codes 8 and 10 sign-extend the result, and codes 9 and 11 zero-extend it.
- R9: Load-left returns memory bytes off..0 in the top bytes of the result and keeps the low (3-off) bytes of `oldDest`. Offset 3 gives the whole memory word.
- R10: Load-right returns memory bytes 3..off in the low bytes of the result and keeps the top `off` bytes of `oldDest`. Offset 0 gives the whole memory word.
- R11: A word load returns `memRdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| effAddr | input | ADDR_W (32) | Effective byte address |
| memOp | input | 4 | Operation code (see R2) |
| storeSrc | input | 32 | Source register value for stores |
| oldDest | input | 32 | Current destination register value, merged by left/right loads |
| memRdata | input | 32 | Word read from memory |
| memAddr | output | ADDR_W (32) | Word-aligned memory address |
| wrStrb | output | 4 | Per-lane write enable |
| wrData | output | 32 | Lane-positioned write word |
| loadResult | output | 32 | Value to write back to the register file |

## Verification
The hardest case to reach is a left or right load. There the result is part memory and part old register, and a boundary that is off by one byte would go unseen if the two sources shared byte values. The stimulus therefore gives every byte of memory, source and old register a distinct value. It sweeps all four offsets for every operation code, and it places bytes with the sign bit set in different lanes, so that both sign extension and merge boundaries are checked byte by byte.

// File: rtl/lsaPkg.sv
`timescale 1ns/1ps
package lsaPkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int OFF_W  = $clog2(LANES);
  localparam int SH_W   = $clog2(DATA_W) + 1;

  localparam logic [3:0] OP_SB  = 4'd1;
  localparam logic [3:0] OP_SH  = 4'd2;
  localparam logic [3:0] OP_SW  = 4'd3;
  localparam logic [3:0] OP_SWL = 4'd4;
  localparam logic [3:0] OP_SWR = 4'd5;
  localparam logic [3:0] OP_LB  = 4'd8;
  localparam logic [3:0] OP_LBU = 4'd9;
  localparam logic [3:0] OP_LH  = 4'd10;
  localparam logic [3:0] OP_LHU = 4'd11;
  localparam logic [3:0] OP_LW  = 4'd12;
  localparam logic [3:0] OP_LWL = 4'd13;
  localparam logic [3:0] OP_LWR = 4'd14;

  typedef enum logic [2:0] {K_BYTE, K_HALF, K_WORD, K_LEFT, K_RIGHT} kind_e;

  typedef struct packed {
    logic             isStore;
    logic             isLoad;
    logic             signExt;
    kind_e            kind;
    logic [OFF_W-1:0] off;
    logic [LANES-1:0] offMask;
  } laneCtl_t;
endpackage

// File: rtl/lsaControl.sv
`timescale 1ns/1ps
module lsaControl
  import lsaPkg::*;
(
  input  logic [3:0]       memOp,
  input  logic [OFF_W-1:0] off,
  output laneCtl_t         ctl,
  output logic [LANES-1:0] wrStrb
);
  logic [LANES-1:0] offMask, halfStrb, leftStrb, rightStrb;

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      assign offMask[i]   = (off == OFF_W'(i));
      assign halfStrb[i]  = ((OFF_W'(i) >> 1) == (off >> 1));
      assign leftStrb[i]  = (OFF_W'(i) <= off);
      assign rightStrb[i] = (OFF_W'(i) >= off);
    end
  endgenerate

  always_comb begin
    ctl         = '0;
    ctl.kind    = K_WORD;
    ctl.off     = off;
    ctl.offMask = offMask;
    case (memOp)
      OP_SB:  begin ctl.isStore = 1'b1; ctl.kind = K_BYTE;  end
      OP_SH:  begin ctl.isStore = 1'b1; ctl.kind = K_HALF;  end
      OP_SW:  begin ctl.isStore = 1'b1; ctl.kind = K_WORD;  end
      OP_SWL: begin ctl.isStore = 1'b1; ctl.kind = K_LEFT;  end
      OP_SWR: begin ctl.isStore = 1'b1; ctl.kind = K_RIGHT; end
      OP_LB:  begin ctl.isLoad = 1'b1; ctl.kind = K_BYTE; ctl.signExt = 1'b1; end
      OP_LBU: begin ctl.isLoad = 1'b1; ctl.kind = K_BYTE; end
      OP_LH:  begin ctl.isLoad = 1'b1; ctl.kind = K_HALF; ctl.signExt = 1'b1; end
      OP_LHU: begin ctl.isLoad = 1'b1; ctl.kind = K_HALF; end
      OP_LW:  begin ctl.isLoad = 1'b1; ctl.kind = K_WORD;  end
      OP_LWL: begin ctl.isLoad = 1'b1; ctl.kind = K_LEFT;  end
      OP_LWR: begin ctl.isLoad = 1'b1; ctl.kind = K_RIGHT; end
      default: ;
    endcase
  end

  always_comb begin
    wrStrb = '0;
    if (ctl.isStore) begin
      case (ctl.kind)
        K_BYTE:  wrStrb = offMask;
        K_HALF:  wrStrb = halfStrb;
        K_LEFT:  wrStrb = leftStrb;
        K_RIGHT: wrStrb = rightStrb;
        default: wrStrb = '1;
      endcase
    end
  end

  always_comb begin
    if (!ctl.isStore) p_nostore_quiet_r2: assert (wrStrb == '0);
    if (ctl.isStore && ctl.kind == K_BYTE)
      p_byte_strb_r3: assert ($countones(wrStrb) == 1 && wrStrb[off]);
    if (ctl.isStore && ctl.kind == K_LEFT)
      p_left_low_lane_r4: assert (wrStrb[0] && wrStrb[off]);
    if (ctl.isStore && ctl.kind == K_RIGHT)
      p_right_top_lane_r4: assert (wrStrb[LANES-1] && wrStrb[off]);
  end
endmodule

// File: rtl/lsaDatapath.sv
`timescale 1ns/1ps
module lsaDatapath
  import lsaPkg::*;
(
  input  laneCtl_t          ctl,
  input  logic [LANES-1:0]  wrStrb,
  input  logic [DATA_W-1:0] storeSrc,
  input  logic [DATA_W-1:0] oldDest,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadResult
);
  localparam int BYTE_LOG = $clog2(BYTE_W);

  logic [SH_W-1:0]     loShift, hiShift;
  logic [DATA_W-1:0]   rawStore, lwlWord, lwrWord, keepLow, keepHigh;
  logic [BYTE_W-1:0]   pickByte;
  logic [2*BYTE_W-1:0] pickHalf;

  assign loShift = SH_W'(ctl.off) << BYTE_LOG;
  assign hiShift = (SH_W'(LANES - 1) - SH_W'(ctl.off)) << BYTE_LOG;

  always_comb begin
    case (ctl.kind)
      K_BYTE:  rawStore = {LANES{storeSrc[BYTE_W-1:0]}};
      K_HALF:  rawStore = {(LANES/2){storeSrc[2*BYTE_W-1:0]}};
      K_LEFT:  rawStore = storeSrc >> hiShift;
      K_RIGHT: rawStore = storeSrc << loShift;
      default: rawStore = storeSrc;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_wlane
      assign wrData[i*BYTE_W +: BYTE_W] =
        (ctl.isStore && wrStrb[i]) ? rawStore[i*BYTE_W +: BYTE_W] : '0;
    end
  endgenerate

  always_comb begin
    pickByte = '0;
    for (int k = 0; k < LANES; k++)
      pickByte |= {BYTE_W{ctl.offMask[k]}} & memRdata[k*BYTE_W +: BYTE_W];
  end

  assign pickHalf = ctl.off[OFF_W-1] ? memRdata[DATA_W-1 -: 2*BYTE_W]
                                     : memRdata[2*BYTE_W-1:0];

  assign keepLow  = (DATA_W'(1) << hiShift) - DATA_W'(1);
  assign keepHigh = ~({DATA_W{1'b1}} >> loShift);
  assign lwlWord  = (memRdata << hiShift) | (oldDest & keepLow);
  assign lwrWord  = (memRdata >> loShift) | (oldDest & keepHigh);

  always_comb begin
    loadResult = '0;
    if (ctl.isLoad) begin
      case (ctl.kind)
        K_BYTE:  loadResult = {{(DATA_W-BYTE_W){ctl.signExt & pickByte[BYTE_W-1]}}, pickByte};
        K_HALF:  loadResult = {{(DATA_W-2*BYTE_W){ctl.signExt & pickHalf[2*BYTE_W-1]}}, pickHalf};
        K_LEFT:  loadResult = lwlWord;
        K_RIGHT: loadResult = lwrWord;
        default: loadResult = memRdata;
      endcase
    end
  end

  always_comb begin
    if (!ctl.isLoad) p_noload_zero_r2: assert (loadResult == '0);
    if (ctl.isStore && ctl.kind == K_WORD)
      p_word_pass_r5: assert (wrData == storeSrc);
    if (ctl.isLoad && ctl.kind == K_BYTE && !ctl.signExt)
      p_zero_ext_r8: assert (loadResult[DATA_W-1:BYTE_W] == '0);
    if (ctl.isLoad && ctl.kind == K_LEFT && ctl.off == OFF_W'(LANES - 1))
      p_left_full_r9: assert (loadResult == memRdata);
    if (ctl.isLoad && ctl.kind == K_RIGHT && ctl.off == '0)
      p_right_full_r10: assert (loadResult == memRdata);
  end
endmodule

// File: rtl/lsaAligner.sv
`timescale 1ns/1ps
module lsaAligner
  import lsaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [3:0]        memOp,
  input  logic [DATA_W-1:0] storeSrc,
  input  logic [DATA_W-1:0] oldDest,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  wrStrb,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] loadResult
);
  laneCtl_t ctl;

  assign memAddr = {effAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsaControl u_ctl (
    .memOp (memOp),
    .off   (effAddr[OFF_W-1:0]),
    .ctl   (ctl),
    .wrStrb(wrStrb)
  );

  lsaDatapath u_dp (
    .ctl       (ctl),
    .wrStrb    (wrStrb),
    .storeSrc  (storeSrc),
    .oldDest   (oldDest),
    .memRdata  (memRdata),
    .wrData    (wrData),
    .loadResult(loadResult)
  );

  always_comb begin
    p_addr_aligned_r1: assert (memAddr[OFF_W-1:0] == '0 &&
                               memAddr[ADDR_W-1:OFF_W] == effAddr[ADDR_W-1:OFF_W]);
  end
endmodule

// File: tb/sim_lsaAligner.sv
`timescale 1ns/1ps
module sim_lsaAligner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] effAddr, storeSrc, oldDest, memRdata;
  logic [3:0]  memOp;
  logic [31:0] memAddr, wrData, loadResult;
  logic [3:0]  wrStrb;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  lsaAligner u0 (
    .effAddr(effAddr), .memOp(memOp), .storeSrc(storeSrc), .oldDest(oldDest),
    .memRdata(memRdata), .memAddr(memAddr), .wrStrb(wrStrb), .wrData(wrData),
    .loadResult(loadResult)
  );

  function automatic logic [7:0] bt(logic [31:0] w, int k);
    return w[k*8 +: 8];
  endfunction

  function automatic logic [3:0] expStrb(int op, int off);
    logic [3:0] s = '0;
    for (int k = 0; k < 4; k++) begin
      case (op)
        1: s[k] = (k == off);
        2: s[k] = ((k / 2) == (off / 2));
        3: s[k] = 1'b1;
        4: s[k] = (k <= off);
        5: s[k] = (k >= off);
        default: s[k] = 1'b0;
      endcase
    end
    return s;
  endfunction

  function automatic logic [31:0] expData(int op, int off, logic [31:0] src);
    logic [3:0]  s = expStrb(op, off);
    logic [31:0] d = '0;
    for (int k = 0; k < 4; k++) begin
      if (s[k]) begin
        case (op)
          1: d[k*8 +: 8] = bt(src, 0);
          2: d[k*8 +: 8] = bt(src, k % 2);
          3: d[k*8 +: 8] = bt(src, k);
          4: d[k*8 +: 8] = bt(src, k + 3 - off);
          default: d[k*8 +: 8] = bt(src, k - off);
        endcase
      end
    end
    return d;
  endfunction

  function automatic logic [31:0] expLoad(int op, int off, logic [31:0] mem, logic [31:0] old);
    logic [31:0] r = '0;
    logic [7:0]  b = bt(mem, off);
    logic [15:0] h = (off >= 2) ? mem[31:16] : mem[15:0];
    case (op)
      8:  r = {{24{b[7]}}, b};
      9:  r = {24'h0, b};
      10: r = {{16{h[15]}}, h};
      11: r = {16'h0, h};
      12: r = mem;
      13: for (int k = 0; k < 4; k++)
            r[k*8 +: 8] = (k >= 3 - off) ? bt(mem, k - (3 - off)) : bt(old, k);
      14: for (int k = 0; k < 4; k++)
            r[k*8 +: 8] = (k <= 3 - off) ? bt(mem, k + off) : bt(old, k);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string strbTag(int op);
    if (op == 4 || op == 5) return "R4";
    if (op >= 1 && op <= 3) return "R3";
    return "R2";
  endfunction

  function automatic string dataTag(int op);
    if (op == 4) return "R6";
    if (op == 5) return "R7";
    if (op >= 1 && op <= 3) return "R5";
    return "R2";
  endfunction

  function automatic string loadTag(int op);
    if (op >= 8 && op <= 11) return "R8";
    if (op == 12) return "R11";
    if (op == 13) return "R9";
    if (op == 14) return "R10";
    return "R2";
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int op, logic [31:0] addr, logic [31:0] src,
                       logic [31:0] old, logic [31:0] mem);
    int off = int'(addr[1:0]);
    @(negedge clk);
    memOp = 4'(op); effAddr = addr; storeSrc = src; oldDest = old; memRdata = mem;
    @(posedge clk);
    #1;
    vectors++;
    check32("R1", "memAddr", memAddr, {addr[31:2], 2'b00});
    check32(strbTag(op), $sformatf("wrStrb op=%0d off=%0d", op, off),
            {28'h0, wrStrb}, {28'h0, expStrb(op, off)});
    check32(dataTag(op), $sformatf("wrData op=%0d off=%0d", op, off),
            wrData, expData(op, off, src));
    check32(loadTag(op), $sformatf("loadResult op=%0d off=%0d", op, off),
            loadResult, expLoad(op, off, mem, old));
  endtask

  logic [31:0] srcPat [4] = '{32'hA1B2C3D4, 32'h0F1E2D3C, 32'h5B6C7D8E, 32'hF0E1D2C3};
  logic [31:0] oldPat [4] = '{32'hDEADBEEF, 32'h11223344, 32'hCAFE705D, 32'h76543219};
  logic [31:0] memPat [4] = '{32'h8C7B6A59, 32'h1F80A27E, 32'h64F5069B, 32'h3A4BDC2D};

  initial begin
    memOp = '0; effAddr = '0; storeSrc = '0; oldDest = '0; memRdata = '0;
    // R2: idle state, code 0 leaves every output quiet
    @(posedge clk);
    #1;
    vectors++;
    check32("R2", "idle wrStrb", {28'h0, wrStrb}, 32'h0);
    check32("R2", "idle wrData", wrData, 32'h0);
    check32("R2", "idle loadResult", loadResult, 32'h0);
    for (int op = 0; op < 16; op++)
      for (int off = 0; off < 4; off++)
        for (int p = 0; p < 4; p++)
          apply(op, {28'h1234567 ^ {24'h0, 4'(p), 4'(op)}, 2'(p), 2'(off)},
                srcPat[p], oldPat[(p + 1) % 4], memPat[(p + off) % 4]);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule